// File: doc/BRIEF.md
# SPI Master Mode and Halt Controller

This block is an SPI master whose behaviour is governed by a small control register. The register holds an operating state: configuration, active or sleep. It also holds a request to halt at a frame boundary, a one-shot flush of both data queues, and the enable and polarity of the chip-select pin. Software queues bytes into a transmit FIFO. Each byte goes out as an 8-bit frame, most significant bit first, in SPI mode 0: the clock idles low, data is driven before the rising edge and sampled on it. Each received byte lands in a receive FIFO that software drains.

Frames begin only in active mode, when the transmit queue holds data and no halt is pending. A halt lets the frame in flight complete and then keeps the engine quiet, even with bytes still queued. Once halted and idle, software may flush both queues. Sleep freezes the shift engine in place and resumes where it stopped. The idle flag tells software when no frame is shifting. The serial clock half-period, counted in system clocks, is a parameter.

Top module: `spi_mode_ctrl`

## Requirements
- R1: After reset the control register reads 0x31 (state 01, halt 0, chip select disabled, active-high polarity), the idle flag is 1, CS is 0, SCLK is 0 and both FIFOs are empty.
- R2: The state field is control bits [1:0]: 01 configuration, 10 active, 11 sleep. A write of 00 leaves the state unchanged. The field reads back from the same bits.
- R3: A frame starts only in active state, with the transmit FIFO non-empty and halt (bit 2) clear. It sends 8 bits MSB first on MOSI, each bit set up while SCLK is low and held across the SCLK rising edge.
- R4: MISO is sampled on each SCLK rising edge, MSB first. At the end of the frame the byte is pushed into the receive FIFO, which is read through the pop port.
- R5: Writing 1 to halt (bit 2) during a frame lets that frame finish. After it, no frame starts while halt stays set, even though the transmit FIFO holds data.
- R6: A write of 1 to halt is ignored unless the state before the write is active.
- R7: A write that puts the state into configuration clears halt.
- R8: Writing 1 to flush (bit 3) empties both FIFOs only if halt is already set and the engine is idle; otherwise the write does nothing. Bit 3 always reads 0.
- R9: When an accepted flush and a transmit push fall in the same cycle, the flush wins and the pushed byte is discarded.
- R10: With chip-select disable (bit 4) at 0, CS shows the active level during a frame: high when polarity (bit 5) is 1, low when it is 0. Otherwise CS holds the inactive level.
- R11: In sleep state SCLK does not toggle, a frame in progress holds its place, and no new frame starts. Returning to active completes the frame with the correct data.
- R12: The idle flag is 0 exactly while a frame is shifting. A frame lasts 16 x HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 6 | Control register write value |
| reg_rd_data | output | 6 | Control register read value |
| tx_push | input | 1 | Push a byte into the transmit FIFO |
| tx_data | input | 8 | Byte to push |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Pop a byte from the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select |
| idle | output | 1 | High when no frame is shifting |

## Verification
An accepted flush and a transmit push can land on the same clock edge. The bench provokes this by driving the flush write and a push together while the engine is halted and idle. The outcome is judged at the ports: the transmit queue reads empty at once. After returning through configuration to active, no frame appears, which shows the pushed byte was discarded rather than queued behind the flush.

// File: rtl/spi_mc_pkg.sv
// Shared types and control field positions for the SPI mode controller.
package spi_mc_pkg;

    // Operating state encoding; 00 in a write means "leave unchanged".
    typedef enum logic [1:0] {
        ST_KEEP  = 2'b00,
        ST_CFG   = 2'b01,
        ST_RUN   = 2'b10,
        ST_SLEEP = 2'b11
    } op_state_t;

    localparam int CTRL_W    = 6;
    localparam int B_HALT    = 2;
    localparam int B_FLUSH   = 3;
    localparam int B_CS_OFF  = 4;
    localparam int B_CS_HIGH = 5;

endpackage

// File: rtl/spi_mc_fifo.sv
// Synchronous FIFO with a clear input.
// Assumes DEPTH is a power of two. Push when full and pop when empty are
// dropped. Clear overrides push and pop in the same cycle.
module spi_mc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp_q, rp_q;
    logic         do_push, do_pop;

    assign empty   = (wp_q == rp_q);
    assign full    = (wp_q[AW-1:0] == rp_q[AW-1:0]) && (wp_q[AW] != rp_q[AW]);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem[rp_q[AW-1:0]];

    // Pointer update: clear resets both, otherwise advance on accepted ops.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q[AW-1:0]] <= wdata;
    end

    // R8/R9: a clear leaves the queue empty on the next cycle.
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

    a_r8_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: rtl/spi_mc_regs.sv
// Control register: operating state, halt, flush strobe, chip-select setup.
// Assumes eng_idle is a registered status from the shift engine. The flush
// strobe is combinational and only lasts for the write cycle.
module spi_mc_regs
    import spi_mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              eng_idle,
    output op_state_t         state,
    output logic              halt,
    output logic              cs_off,
    output logic              cs_high,
    output logic              flush,
    output logic [CTRL_W-1:0] rd_data
);
    op_state_t wr_state, nxt_state;

    assign wr_state  = op_state_t'(wr_data[1:0]);
    assign nxt_state = (wr_state == ST_KEEP) ? state : wr_state;

    // Flush accepted only when halted and idle, using pre-write halt.
    assign flush   = wr_en && wr_data[B_FLUSH] && halt && eng_idle;
    assign rd_data = {cs_high, cs_off, 1'b0, halt, state};

    // Register update on writes; configuration entry forces halt low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CFG;
            halt    <= 1'b0;
            cs_off  <= 1'b1;
            cs_high <= 1'b1;
        end else if (wr_en) begin
            state   <= nxt_state;
            cs_off  <= wr_data[B_CS_OFF];
            cs_high <= wr_data[B_CS_HIGH];
            if (nxt_state == ST_CFG)
                halt <= 1'b0;
            else if (!wr_data[B_HALT])
                halt <= 1'b0;
            else if (state == ST_RUN)
                halt <= 1'b1;
        end
    end

    // R6: halt can only rise out of the active state.
    a_r6_halt_from_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(state) == ST_RUN);

    // R7: configuration state never coexists with halt.
    a_r7_cfg_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CFG) |-> !halt);

endmodule

// File: rtl/spi_mc_shifter.sv
// SPI mode 0 shift engine, MSB first, fixed W-bit frames.
// Assumes the transmit head byte is valid whenever tx_empty is low. Each
// SCLK half period lasts HALF_DIV clocks. Sleep freezes all progress.
module spi_mc_shifter
    import spi_mc_pkg::*;
#(
    parameter int W        = 8,
    parameter int HALF_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  op_state_t    state,
    input  logic         halt,
    input  logic         flush,
    input  logic         tx_empty,
    input  logic [W-1:0] tx_byte,
    input  logic         miso,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_byte,
    output logic         sclk,
    output logic         mosi,
    output logic         busy
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] div_q;
    logic [BW-1:0] bit_q;
    logic [W-1:0]  tx_sh_q, rx_sh_q;
    logic          phase_q, busy_q;
    logic          start, run, tick, last;

    assign start = !busy_q && (state == ST_RUN) && !halt && !flush && !tx_empty;
    assign run   = busy_q && (state != ST_SLEEP);
    assign tick  = run && (div_q == CW'(HALF_DIV - 1));
    assign last  = tick && phase_q && (bit_q == BW'(W - 1));

    assign tx_pop  = start;
    assign rx_push = last;
    assign rx_byte = rx_sh_q;
    assign sclk    = phase_q;
    assign mosi    = tx_sh_q[W-1];
    assign busy    = busy_q;

    // Frame sequencer: load on start, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            tx_sh_q <= tx_byte;
        end else if (run) begin
            if (!tick) begin
                div_q <= div_q + 1'b1;
            end else begin
                div_q <= '0;
                if (!phase_q) begin
                    phase_q <= 1'b1;
                    rx_sh_q <= {rx_sh_q[W-2:0], miso};
                end else begin
                    phase_q <= 1'b0;
                    if (bit_q == BW'(W - 1)) begin
                        busy_q <= 1'b0;
                    end else begin
                        bit_q   <= bit_q + 1'b1;
                        tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R3/R5: a frame begins only from active state with no halt pending.
    a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(state == ST_RUN && !halt && !tx_empty));

    // R11: the serial clock never moves after a sleeping cycle.
    a_r11_sleep_holds_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_SLEEP) |-> $stable(phase_q));

    // R12: SCLK rests low whenever no frame is shifting.
    a_r12_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !phase_q);

endmodule

// File: rtl/spi_mode_ctrl.sv
// SPI master top: control register, transmit/receive FIFOs, shift engine
// and chip-select output.
// Assumes a single slave. CS follows the frame, with programmable enable
// and polarity.
module spi_mode_ctrl
    import spi_mc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int HALF_DIV   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wr_data,
    output logic [CTRL_W-1:0] reg_rd_data,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs,
    output logic              idle
);
    op_state_t         state;
    logic              halt, cs_off, cs_high, flush, busy;
    logic              eng_pop, eng_push, rx_full;
    logic [DATA_W-1:0] tx_head, rx_word;

    spi_mc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .eng_idle (!busy),
        .state    (state),
        .halt     (halt),
        .cs_off   (cs_off),
        .cs_high  (cs_high),
        .flush    (flush),
        .rd_data  (reg_rd_data)
    );

    spi_mc_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (eng_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_mc_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (eng_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .rdata (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_mc_shifter #(.W(DATA_W), .HALF_DIV(HALF_DIV)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .halt     (halt),
        .flush    (flush),
        .tx_empty (tx_empty),
        .tx_byte  (tx_head),
        .miso     (miso),
        .tx_pop   (eng_pop),
        .rx_push  (eng_push),
        .rx_byte  (rx_word),
        .sclk     (sclk),
        .mosi     (mosi),
        .busy     (busy)
    );

    // Chip select: active level only while a frame shifts and CS is enabled.
    always_comb begin
        if (busy && !cs_off) cs = cs_high;
        else                 cs = !cs_high;
    end

    assign idle = !busy;

    // R4: a received byte is never offered into a full receive queue unnoticed.
    a_r4_rx_push_space: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_push && !rx_full) |=> !rx_empty);

    // R5: with halt held, an idle engine stays idle.
    a_r5_halt_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halt) && halt && $past(!busy)) |-> !busy);

endmodule

// File: tb/tb_spi_mode_ctrl.sv
// Directed bench for spi_mode_ctrl; MISO is MOSI inverted, so each received
// byte should be the complement of the byte sent.
module tb_spi_mode_ctrl;
    localparam int DIV   = 2;
    localparam int FRAME = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [5:0] reg_wr_data = '0;
    logic [5:0] reg_rd_data;
    logic       tx_push = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_full, tx_empty;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_empty, sclk, mosi, miso, cs, idle;

    int checks = 0;
    int fails  = 0;

    spi_mode_ctrl #(.DATA_W(8), .FIFO_DEPTH(4), .HALF_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs(cs), .idle(idle)
    );

    assign miso = ~mosi;
    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk);
        tx_push = 1'b1; tx_data = v;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop(output logic [7:0] v);
        @(negedge clk);
        v = rx_data; rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_busy(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            if (!idle) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic idle_hold(input int n, input string tag);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!idle) lows++;
        end
        check(lows == 0, tag, lows, 0);
    endtask

    // Follow one frame at the pins: length, MOSI bits at SCLK rises, CS.
    task automatic run_frame(input logic [7:0] exp_tx, input logic act_lvl,
                             input logic inact_lvl, input string tag);
        bit seen;
        int cyc = 0, cs_bad = 0, nbits = 0;
        logic [7:0] got = '0;
        logic prev = 1'b0;
        wait_busy(seen);
        check(seen, {tag, " R3 frame start"}, seen, 1);
        while (!idle && cyc < 4 * FRAME) begin
            cyc++;
            if (cs !== act_lvl) cs_bad++;
            if (sclk && !prev) begin
                got = {got[6:0], mosi};
                nbits++;
            end
            prev = sclk;
            @(negedge clk);
        end
        check(cyc == FRAME, {tag, " R12 frame length"}, cyc, FRAME);
        check(got == exp_tx && nbits == 8, {tag, " R3 MOSI bits"}, got, exp_tx);
        check(cs_bad == 0, {tag, " R10 CS during frame"}, cs_bad, 0);
        check(cs == inact_lvl, {tag, " R10 CS after frame"}, cs, inact_lvl);
    endtask

    task automatic t_reset();
        check(reg_rd_data == 6'h31, "R1 register", reg_rd_data, 6'h31);
        check(idle && !cs && !sclk, "R1 pins", {idle, cs, sclk}, 3'b100);
        check(tx_empty && rx_empty, "R1 fifos", {tx_empty, rx_empty}, 2'b11);
    endtask

    task automatic t_modes();
        wr_reg(6'h32);
        check(reg_rd_data == 6'h32, "R2 active", reg_rd_data, 6'h32);
        wr_reg(6'h30);
        check(reg_rd_data == 6'h32, "R2 keep on 00", reg_rd_data, 6'h32);
        wr_reg(6'h33);
        check(reg_rd_data == 6'h33, "R2 sleep", reg_rd_data, 6'h33);
        wr_reg(6'h31);
        check(reg_rd_data == 6'h31, "R2 config", reg_rd_data, 6'h31);
    endtask

    task automatic t_frame();
        logic [7:0] r;
        push(8'hA5);
        idle_hold(20, "R3 no start in config");
        wr_reg(6'h22);
        run_frame(8'hA5, 1'b1, 1'b0, "hi-pol");
        pop(r);
        check(r == 8'h5A, "R4 received byte", r, 8'h5A);
        check(rx_empty, "R4 rx drained", rx_empty, 1);
    endtask

    task automatic t_stop();
        bit seen;
        push(8'h11);
        push(8'h22);
        push(8'h33);
        wait_busy(seen);
        wr_reg(6'h26);
        for (int i = 0; i < 4 * FRAME && !idle; i++) @(negedge clk);
        check(idle, "R5 current frame ends", idle, 1);
        idle_hold(3 * FRAME, "R5 no frame after halt");
        check(!tx_empty && !rx_empty, "R5 queues hold data", {tx_empty, rx_empty}, 2'b00);
        check(reg_rd_data == 6'h26, "R5 halt reads set", reg_rd_data, 6'h26);
    endtask

    task automatic t_flush_collision();
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 6'h2E;
        tx_push = 1'b1; tx_data = 8'h77;
        @(negedge clk);
        reg_wr_en = 1'b0; tx_push = 1'b0;
        check(tx_empty, "R9 flush beats push", tx_empty, 1);
        check(rx_empty, "R8 rx flushed", rx_empty, 1);
        check(reg_rd_data == 6'h26, "R8 flush reads 0", reg_rd_data, 6'h26);
        wr_reg(6'h21);
        check(reg_rd_data == 6'h21, "R7 config clears halt", reg_rd_data, 6'h21);
        wr_reg(6'h22);
        idle_hold(3 * FRAME, "R9 pushed byte discarded");
        check(tx_empty, "R9 tx still empty", tx_empty, 1);
    endtask

    task automatic t_flush_refused();
        wr_reg(6'h21);
        push(8'h3C);
        wr_reg(6'h29);
        check(!tx_empty, "R8 flush refused without halt", tx_empty, 0);
        check(reg_rd_data == 6'h21, "R8 refused reads", reg_rd_data, 6'h21);
    endtask

    task automatic t_halt_ignored();
        wr_reg(6'h25);
        check(reg_rd_data == 6'h21, "R6 halt ignored in config", reg_rd_data, 6'h21);
        wr_reg(6'h23);
        wr_reg(6'h27);
        check(reg_rd_data == 6'h23, "R6 halt ignored in sleep", reg_rd_data, 6'h23);
        idle_hold(2 * FRAME, "R11 no start in sleep");
    endtask

    task automatic t_sleep();
        bit seen;
        logic [7:0] r;
        int moves = 0, lows = 0;
        logic s0;
        wr_reg(6'h22);
        wait_busy(seen);
        repeat (5) @(negedge clk);
        wr_reg(6'h23);
        s0 = sclk;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sclk !== s0) moves++;
            if (!idle) lows++;
        end
        check(moves == 0, "R11 SCLK frozen", moves, 0);
        check(lows == 20, "R11 frame held, idle low", lows, 20);
        wr_reg(6'h22);
        for (int i = 0; i < 4 * FRAME && !idle; i++) @(negedge clk);
        pop(r);
        check(r == 8'hC3, "R11 resumed frame data", r, 8'hC3);
    endtask

    task automatic t_cs();
        logic [7:0] r;
        wr_reg(6'h01);
        check(cs == 1'b1, "R10 active-low idle level", cs, 1);
        push(8'h96);
        wr_reg(6'h02);
        run_frame(8'h96, 1'b0, 1'b1, "lo-pol");
        pop(r);
        check(r == 8'h69, "R4 second byte", r, 8'h69);
        wr_reg(6'h11);
        push(8'h69);
        wr_reg(6'h12);
        run_frame(8'h69, 1'b1, 1'b1, "cs-off");
        pop(r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_frame();
        t_stop();
        t_flush_collision();
        t_flush_refused();
        t_halt_ignored();
        t_sleep();
        t_cs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule